// File: doc/BRIEF.md
# Fixed-Point Status Flag Generator

This block derives the status flags of an integer operation from its operands and its result. The flags are carry, low-half carry, overflow, low-half overflow, a sticky summary-overflow bit and a four-bit condition nibble. The arithmetic unit is outside the block. Each operation arrives as one strobed beat carrying:

- the first operand, with an optional bitwise inversion;
- an optional second register operand;
- an optional immediate;
- the result;
- operation-class and enable controls;
- the flag values currently held in the status register.

Carry comes from unsigned comparison rather than from an adder chain. Any input that is unsigned-greater than the result marks a carry-out. For additions, the low-half carry instead follows a parity rule at bit `XLEN/2`. Overflow compares the signs of the first two inputs with the sign of the result. A divider can override overflow with its own indication. Summary overflow only accumulates.

Every flag that an operation does not update is passed through from its incoming value. The output word is therefore the complete next status state. All outputs are registered and appear one cycle after the input strobe, together with a valid pulse.

Top module: `flag_gen`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, all flag outputs update at that edge and `out_valid` is high for exactly the following cycle. When `in_valid` is low, `out_valid` is low and every flag output holds its value.
- R2: When `invert_a` is 1, the first operand is bitwise complemented before any flag is computed.
- R3: The inputs list is the first operand, then `op_b` if `b_valid` is set, then `imm` if `imm_valid` is set. For overflow and for the add-type low-half carry, the second input is `op_b` when present, otherwise `imm`.
- R4: When `carry_en`=1 and `is_add`=0, the flags are set as follows:
  - `ca` is 1 when any input is unsigned-greater than `result`.
  - `ca32` applies the same rule to bits `[XLEN/2-1:0]`.
- R5: When `carry_en`=1 and `is_add`=1, `ca32` is the XOR of `result[XLEN/2]`, the first input's bit `XLEN/2`, and the second input's bit `XLEN/2`. That last term is taken as 0 when there is no second input. `ca` still follows R4.
- R6: When `carry_en`=0, `ca` passes `ca_in` through and `ca32` passes `ca32_in` through. `ca_explicit`=1 keeps `ca`=`ca_in`, and `ca32_explicit`=1 keeps `ca32`=`ca32_in`.
- R7: When overflow is updated without override, `ov` is 1 when the first two inputs share a sign bit (bit `XLEN-1`) and the result's sign differs. `ov32` applies the same rule with bit `XLEN/2-1` as the sign.
- R8: Overflow is updated only when `ov_en`=1 and either `div_ov_valid`=1 or there are at least two inputs. `div_ov_valid`=1 forces both `ov` and `ov32` to `div_ov`. When not updated, `ov`=`ov_in` and `ov32`=`ov32_in`.
- R9: `so` is `so_in` ORed with the new `ov` when overflow is updated, and `so_in` otherwise. It never clears when `so_in`=1.
- R10: When `rec_en`=1, `cr` is `{negative, positive, zero, so}` (bit 3 down to bit 0) from a signed comparison of `result` with zero, using the new `so`. When `rec_en`=0, `cr` holds its previous value.
- R11: While `rst_n` is low, `out_valid`, all flags and `cr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat strobe |
| op_a | input | XLEN | First operand |
| invert_a | input | 1 | Complement the first operand |
| op_b | input | XLEN | Second register operand |
| b_valid | input | 1 | Second register operand present |
| imm | input | XLEN | Immediate operand |
| imm_valid | input | 1 | Immediate present |
| result | input | XLEN | Operation result |
| is_add | input | 1 | Add-class operation |
| carry_en | input | 1 | Update carry flags |
| ca_explicit | input | 1 | Operation writes carry itself |
| ca32_explicit | input | 1 | Operation writes low-half carry itself |
| ov_en | input | 1 | Update overflow flags |
| div_ov_valid | input | 1 | Division overflow override present |
| div_ov | input | 1 | Division overflow value |
| rec_en | input | 1 | Update condition nibble |
| ca_in | input | 1 | Current carry |
| ca32_in | input | 1 | Current low-half carry |
| ov_in | input | 1 | Current overflow |
| ov32_in | input | 1 | Current low-half overflow |
| so_in | input | 1 | Current summary overflow |
| out_valid | output | 1 | Output beat strobe |
| ca | output | 1 | Next carry |
| ca32 | output | 1 | Next low-half carry |
| ov | output | 1 | Next overflow |
| ov32 | output | 1 | Next low-half overflow |
| so | output | 1 | Next summary overflow |
| cr | output | 4 | Condition nibble {neg, pos, zero, so} |

## Verification
The bench builds the block with `XLEN`=8, so the low half is four bits wide. At that width, a full sweep of the first operand against every third result value is affordable. That sweep reaches every unsigned ordering, every sign combination at both sign bits, and both values of bit 4 for the parity rule.

A second phase draws all control inputs and the other operands from a shift register. This covers every combination of operand presence, inversion, explicit-write and override together with held-nibble behaviour. Idle cycles with disturbed inputs confirm that outputs hold between strobes.

// File: rtl/flag_gen.sv
module flag_gen #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] op_a,
  input  logic            invert_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            b_valid,
  input  logic [XLEN-1:0] imm,
  input  logic            imm_valid,
  input  logic [XLEN-1:0] result,
  input  logic            is_add,
  input  logic            carry_en,
  input  logic            ca_explicit,
  input  logic            ca32_explicit,
  input  logic            ov_en,
  input  logic            div_ov_valid,
  input  logic            div_ov,
  input  logic            rec_en,
  input  logic            ca_in,
  input  logic            ca32_in,
  input  logic            ov_in,
  input  logic            ov32_in,
  input  logic            so_in,
  output logic            out_valid,
  output logic            ca,
  output logic            ca32,
  output logic            ov,
  output logic            ov32,
  output logic            so,
  output logic [3:0]      cr
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] a_eff, second;
  logic            has_second;

  assign a_eff      = invert_a ? ~op_a : op_a;
  assign has_second = b_valid | imm_valid;
  assign second     = b_valid ? op_b : imm;

  logic gt_full, gt_low;
  assign gt_full = (a_eff > result)
                 | (b_valid   & (op_b > result))
                 | (imm_valid & (imm  > result));
  assign gt_low  = (a_eff[HALF-1:0] > result[HALF-1:0])
                 | (b_valid   & (op_b[HALF-1:0] > result[HALF-1:0]))
                 | (imm_valid & (imm[HALF-1:0]  > result[HALF-1:0]));

  logic par32;
  assign par32 = result[HALF] ^ a_eff[HALF] ^ (has_second & second[HALF]);

  logic ca_n, ca32_n;
  assign ca_n   = (carry_en & ~ca_explicit)   ? gt_full : ca_in;
  assign ca32_n = (carry_en & ~ca32_explicit) ? (is_add ? par32 : gt_low) : ca32_in;

  logic ov_ar, ov32_ar, ov_upd, ov_n, ov32_n, so_n;
  assign ov_ar   = (a_eff[XLEN-1] == second[XLEN-1]) & (result[XLEN-1] != a_eff[XLEN-1]);
  assign ov32_ar = (a_eff[HALF-1] == second[HALF-1]) & (result[HALF-1] != a_eff[HALF-1]);
  assign ov_upd  = ov_en & (div_ov_valid | has_second);
  assign ov_n    = ov_upd ? (div_ov_valid ? div_ov : ov_ar)   : ov_in;
  assign ov32_n  = ov_upd ? (div_ov_valid ? div_ov : ov32_ar) : ov32_in;
  assign so_n    = so_in | (ov_upd & ov_n);

  logic r_neg, r_zero;
  assign r_neg  = result[XLEN-1];
  assign r_zero = (result == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ca <= 1'b0; ca32 <= 1'b0; ov <= 1'b0; ov32 <= 1'b0; so <= 1'b0;
      cr <= 4'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ca   <= ca_n;
        ca32 <= ca32_n;
        ov   <= ov_n;
        ov32 <= ov32_n;
        so   <= so_n;
        if (rec_en) cr <= {r_neg, ~r_neg & ~r_zero, r_zero, so_n};
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(ca) && $stable(ov) && $stable(so) && $stable(cr)));
  // R6
  ca_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!carry_en || ca_explicit)) |=> (ca == $past(ca_in)));
  // R8
  div_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ov_en && div_ov_valid) |=> (ov == $past(div_ov) && ov32 == $past(div_ov)));
  // R9
  so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && so_in) |=> so);
  // R10
  cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rec_en) |=> ($countones(cr[3:1]) == 1 && cr[0] == so));
endmodule

// File: tb/flag_gen_bench.sv
module flag_gen_bench;
  localparam int W = 8;
  localparam int H = W / 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, imm = '0, result = '0;
  logic invert_a = 0, b_valid = 0, imm_valid = 0, is_add = 0, carry_en = 0;
  logic ca_explicit = 0, ca32_explicit = 0, ov_en = 0, div_ov_valid = 0, div_ov = 0;
  logic rec_en = 0, ca_in = 0, ca32_in = 0, ov_in = 0, ov32_in = 0, so_in = 0;
  logic out_valid, ca, ca32, ov, ov32, so;
  logic [3:0] cr;

  int checks = 0, fails = 0;
  logic [3:0] exp_cr = 4'd0;
  logic e_ca, e_ca32, e_ov, e_ov32, e_so;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_gen #(.XLEN(W)) u_flag_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .invert_a(invert_a),
    .op_b(op_b), .b_valid(b_valid), .imm(imm), .imm_valid(imm_valid), .result(result),
    .is_add(is_add), .carry_en(carry_en), .ca_explicit(ca_explicit),
    .ca32_explicit(ca32_explicit), .ov_en(ov_en), .div_ov_valid(div_ov_valid),
    .div_ov(div_ov), .rec_en(rec_en), .ca_in(ca_in), .ca32_in(ca32_in), .ov_in(ov_in),
    .ov32_in(ov32_in), .so_in(so_in), .out_valid(out_valid), .ca(ca), .ca32(ca32),
    .ov(ov), .ov32(ov32), .so(so), .cr(cr));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic model();
    logic [W-1:0] ae, sec;
    logic two, upd, nv, nv32;
    ae  = invert_a ? ~op_a : op_a;
    sec = b_valid ? op_b : imm;
    two = b_valid || imm_valid;
    if (!carry_en || ca_explicit) e_ca = ca_in;
    else e_ca = (ae > result) || (b_valid && op_b > result) || (imm_valid && imm > result);
    if (!carry_en || ca32_explicit) e_ca32 = ca32_in;
    else if (is_add) e_ca32 = result[H] ^ ae[H] ^ (two ? sec[H] : 1'b0);
    else e_ca32 = (ae[H-1:0] > result[H-1:0]) || (b_valid && op_b[H-1:0] > result[H-1:0])
                  || (imm_valid && imm[H-1:0] > result[H-1:0]);
    upd  = ov_en && (div_ov_valid || two);
    nv   = (($signed(ae) < 0) == ($signed(sec) < 0)) && (($signed(result) < 0) != ($signed(ae) < 0));
    nv32 = (($signed(ae[H-1:0]) < 0) == ($signed(sec[H-1:0]) < 0)) &&
           (($signed(result[H-1:0]) < 0) != ($signed(ae[H-1:0]) < 0));
    e_ov   = upd ? (div_ov_valid ? div_ov : nv)   : ov_in;
    e_ov32 = upd ? (div_ov_valid ? div_ov : nv32) : ov32_in;
    e_so   = so_in | (upd & e_ov);
    if (rec_en) exp_cr = {$signed(result) < 0, $signed(result) > 0, result == 0, e_so};
  endtask

  task automatic run_vec();
    string ctag;
    model();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ctag = (!carry_en || ca_explicit) ? "R6 ca" : "R4 ca";
    check(ctag, ca, e_ca);
    ctag = (!carry_en || ca32_explicit) ? "R6 ca32" : (is_add ? "R5 ca32" : "R4 ca32");
    check(ctag, ca32, e_ca32);
    ctag = div_ov_valid ? "R8 ov" : "R7 ov";
    check(ctag, ov, e_ov);
    check(ctag, ov32, e_ov32);
    check("R9 so", so, e_so);
    check("R10 cr", cr, exp_cr);
    check("R1 out_valid", out_valid, 1);
  endtask

  task automatic rand_ctrl();
    step_lfsr();
    {invert_a, b_valid, imm_valid, is_add, carry_en, ca_explicit, ca32_explicit, ov_en} = lfsr[7:0];
    {div_ov_valid, div_ov, rec_en, ca_in, ca32_in, ov_in, ov32_in, so_in} = lfsr[15:8];
    ca_explicit   = ca_explicit & lfsr[16];
    ca32_explicit = ca32_explicit & lfsr[17];
    div_ov_valid  = div_ov_valid & lfsr[18];
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 out_valid", out_valid, 0);
    check("R11 flags", {ca, ca32, ov, ov32, so}, 0);
    check("R11 cr", cr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R7: sweep first operand against results, two register inputs
    for (int a = 0; a < 256; a++) begin
      for (int r = 0; r < 256; r += 3) begin
        op_a = a[7:0]; result = r[7:0];
        op_b = 8'(a * 7 + r) ^ 8'h5A;
        invert_a = 0; b_valid = 1; imm_valid = 0; is_add = r[0];
        carry_en = 1; ca_explicit = 0; ca32_explicit = 0;
        ov_en = 1; div_ov_valid = 0; rec_en = 1;
        {ca_in, ca32_in, ov_in, ov32_in, so_in} = 5'(a ^ r) & 5'b11110;
        run_vec();
      end
    end

    // R2 R3 R6 R8 R9 R10: random controls, operand presence and overrides
    for (int i = 0; i < 4000; i++) begin
      rand_ctrl();
      step_lfsr(); op_a = lfsr[7:0]; op_b = lfsr[15:8]; imm = lfsr[23:16]; result = lfsr[31:24];
      if (i % 16 == 0) result = 8'h00;
      if (i % 16 == 1) result = 8'h80;
      run_vec();
      if (i % 8 == 0) begin
        // R1 hold with disturbed inputs and no strobe
        rand_ctrl(); result = ~result;
        @(negedge clk);
        check("R1 idle out_valid", out_valid, 0);
        check("R1 hold flags", {ca, ca32, ov, ov32, so}, {e_ca, e_ca32, e_ov, e_ov32, e_so});
        check("R1 hold cr", cr, exp_cr);
      end
    end

    // R2 directed: inversion turns 0x00 into 0xFF > result 0x10
    op_a = 8'h00; invert_a = 1; b_valid = 0; imm_valid = 0; result = 8'h10;
    carry_en = 1; ca_explicit = 0; ca32_explicit = 0; is_add = 0; ov_en = 0; rec_en = 0;
    ca_in = 0; ca32_in = 0; so_in = 0; div_ov_valid = 0;
    run_vec();
    check("R2 inverted carry", ca, 1);
    // R3 directed: immediate alone as second input drives overflow
    op_a = 8'h70; invert_a = 0; imm = 8'h70; imm_valid = 1; result = 8'hE0;
    carry_en = 0; ov_en = 1; ov_in = 0; ov32_in = 0;
    run_vec();
    check("R3 imm overflow", ov, 1);
    // R8 directed: single input, no override, overflow held
    imm_valid = 0; ov_in = 1; ov32_in = 0;
    run_vec();
    check("R8 ov held", {ov, ov32}, 2'b10);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule